// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block sits beside an I2C master and decides when a start condition may be driven onto the bus. Software raises a one-cycle start request at any time. If the bus is currently free, the block issues the start at once. If another transfer owns the bus, the request is kept as a pending reservation. The start then goes out by itself on the next stop condition, provided the stop-interrupt enable is set.

After either kind of start, the block holds the clock low (wait state) until software writes the shift register. That write launches the master address transfer. Every accepted request also starts a down-counter whose length depends on the transfer clock mode. Software should read the master-status flag only once the counter has expired, which is shown on a status-valid output.

Line drivers, bit shifting, arbitration detection and acknowledge handling live elsewhere. They reach this block only as single-cycle strobes.

Top module: `i2c_start_rsv`

## Requirements
- R1: A synchronous active-low reset gives an idle block: `gen_start`, `hold_wait`, `master_flag`, `addr_launch` and `rsv_pending` low, `status_valid` high, and the bus taken as free, so a later request starts at once.
- R2: A `start_req` accepted while idle with the bus free raises `gen_start` for exactly the next cycle, and raises `master_flag` and `hold_wait` in that same cycle.
- R3: A `start_req` while idle with the bus busy and `stop_int_en` high raises `rsv_pending` in the next cycle and drives no start.
- R4: The bus turns busy on a `start_det` or on a start this block fires. It turns free again on any of three strobes: `stop_det`, `arb_none` (arbitration left the device neither master nor slave), or `sw_release` (the bus was released by software after an extension code, with no acknowledge returned).
- R5: While `rsv_pending` is high, a `stop_det` with `stop_int_en` high fires `gen_start` for one cycle in the next cycle. In that cycle `hold_wait` and `master_flag` are high and `rsv_pending` is low.
- R6: While `hold_wait` is high, `shift_wr` gives a one-cycle `addr_launch` in the next cycle, drops `hold_wait` and keeps `master_flag`. A later `stop_det` clears `master_flag`.
- R7: With `stop_int_en` low, a request on a busy bus is ignored: no reservation and no change to `status_valid`. A pending reservation is dropped in the cycle after `stop_int_en` goes low, and a later `stop_det` fires no start.
- R8: An accepted request loads the wait counter. `status_valid` is then low for exactly 26 cycles when `clk_mode` is 00, 46 cycles for 01, and 16 cycles for 10 or 11, counted from the cycle after the request.
- R9: A `start_det` while `rsv_pending` is high (another master won the bus) cancels the reservation and leaves `master_flag` low.
- R10: A `start_req` while a reservation is pending, or while the block is master, is ignored. The reservation stays in place and the wait counter is not reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle start request from software |
| stop_int_en | input | 1 | Stop-condition interrupt enable; arms reservations |
| start_det | input | 1 | Start condition seen on the bus |
| stop_det | input | 1 | Stop condition seen on the bus |
| arb_none | input | 1 | Arbitration left the device neither master nor slave |
| sw_release | input | 1 | Bus released by software after an unacknowledged extension code |
| shift_wr | input | 1 | Software write to the shift register |
| clk_mode | input | 2 | Transfer clock mode bits selecting the wait length |
| gen_start | output | 1 | One-cycle command to drive a start condition |
| hold_wait | output | 1 | Hold the clock low until the address is written |
| master_flag | output | 1 | Block owns the bus as master |
| addr_launch | output | 1 | One-cycle pulse launching the address transfer |
| rsv_pending | output | 1 | A reservation is waiting for a stop condition |
| status_valid | output | 1 | Wait period has expired; `master_flag` may be read |

## Verification
The hardest case to reach is a reservation that meets a competing event: a second request, a foreign start, or a dropped enable, each arriving before the stop. The stimulus gets there by first marking the bus busy with a lone `start_det`, then placing the request, then applying the competing strobe in the very next cycle. A second hard case is the wait length. The bench cannot see the counter, so it counts the cycles `status_valid` stays low in each clock mode. It also repeats that count with a second request placed mid-wait, to show the counter was not reloaded.

// File: rtl/i2c_start_rsv_pkg.sv
// Package i2c_start_rsv_pkg
// Shared state encoding for the start reservation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_start_rsv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no request outstanding
        ST_RSV  = 2'd1,   // reservation waiting for a stop condition
        ST_HOLD = 2'd2,   // start issued, clock held until address write
        ST_XFER = 2'd3    // address launched, master until stop
    } rsv_state_e;

    typedef struct packed {
        logic fire;       // issue a start now
        logic load;       // request accepted; load wait counter
        logic launch;     // address transfer launch
    } rsv_evt_t;

endpackage

// File: rtl/i2c_bus_tracker.sv
// Module i2c_bus_tracker
// Keeps a single flag telling whether the bus is free for a start.
// Assumes: event strobes are one cycle wide and already synchronised.
// Own start (fire) has top priority, then release events, then foreign start.
module i2c_bus_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic start_det,
    input  logic stop_det,
    input  logic arb_none,
    input  logic sw_release,
    output logic bus_free
);

    logic release_evt;

    // Any of the three events that leave the bus unused.
    always_comb begin
        release_evt = stop_det | arb_none | sw_release;
    end

    // Track free/busy; reset assumes a released bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_free <= 1'b1;
        end else if (fire) begin
            bus_free <= 1'b0;
        end else if (release_evt) begin
            bus_free <= 1'b1;
        end else if (start_det) begin
            bus_free <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_wait_timer.sv
// Module i2c_wait_timer
// Down-counter that gives the settle time before master status is valid.
// Assumes: load is a one-cycle strobe; the length is picked by the mode bits.
// Mode 00 -> LEN_M0, 01 -> LEN_M1, 1x -> LEN_M2.
module i2c_wait_timer #(
    parameter int LEN_M0 = 26,
    parameter int LEN_M1 = 46,
    parameter int LEN_M2 = 16,
    localparam int LEN_MAX = (LEN_M0 > LEN_M1) ?
                             ((LEN_M0 > LEN_M2) ? LEN_M0 : LEN_M2) :
                             ((LEN_M1 > LEN_M2) ? LEN_M1 : LEN_M2),
    localparam int CNT_W = $clog2(LEN_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] mode,
    output logic       expired
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_sel;

    // Pick the wait length from the mode bits.
    always_comb begin
        if (mode[1]) begin
            len_sel = CNT_W'(LEN_M2);
        end else if (mode[0]) begin
            len_sel = CNT_W'(LEN_M1);
        end else begin
            len_sel = CNT_W'(LEN_M0);
        end
    end

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len_sel;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Status is valid once the counter is empty.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/i2c_rsv_fsm.sv
// Module i2c_rsv_fsm
// Sequencer for immediate starts, reservations, clock hold and address launch.
// Assumes: bus_free comes from i2c_bus_tracker one cycle behind bus events.
// Only one reservation is held; requests outside idle are ignored.
module i2c_rsv_fsm
    import i2c_start_rsv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_req,
    input  logic     stop_int_en,
    input  logic     start_det,
    input  logic     stop_det,
    input  logic     shift_wr,
    input  logic     bus_free,
    output rsv_evt_t evt,
    output logic     gen_start,
    output logic     hold_wait,
    output logic     master_flag,
    output logic     addr_launch,
    output logic     rsv_pending
);

    rsv_state_e state_q;
    rsv_state_e state_d;

    // Next state and one-cycle events for this cycle.
    always_comb begin
        state_d    = state_q;
        evt        = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    if (bus_free) begin
                        state_d  = ST_HOLD;
                        evt.fire = 1'b1;
                        evt.load = 1'b1;
                    end else if (stop_int_en) begin
                        state_d  = ST_RSV;
                        evt.load = 1'b1;
                    end
                end
            end
            ST_RSV: begin
                if (!stop_int_en) begin
                    state_d = ST_IDLE;
                end else if (start_det) begin
                    state_d = ST_IDLE;
                end else if (stop_det) begin
                    state_d  = ST_HOLD;
                    evt.fire = 1'b1;
                end
            end
            ST_HOLD: begin
                if (stop_det) begin
                    state_d = ST_IDLE;
                end else if (shift_wr) begin
                    state_d    = ST_XFER;
                    evt.launch = 1'b1;
                end
            end
            ST_XFER: begin
                if (stop_det) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_start   <= 1'b0;
            addr_launch <= 1'b0;
        end else begin
            gen_start   <= evt.fire;
            addr_launch <= evt.launch;
        end
    end

    // Registered level outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_wait   <= 1'b0;
            master_flag <= 1'b0;
            rsv_pending <= 1'b0;
        end else begin
            hold_wait   <= (state_d == ST_HOLD);
            master_flag <= (state_d == ST_HOLD) || (state_d == ST_XFER);
            rsv_pending <= (state_d == ST_RSV);
        end
    end

endmodule

// File: rtl/i2c_start_rsv.sv
// Module i2c_start_rsv (top)
// Start reservation controller for an I2C master: immediate or deferred
// start, clock hold until address write, and a mode-dependent settle timer.
// Assumes: all bus strobes are synchronous, one cycle wide.
module i2c_start_rsv
    import i2c_start_rsv_pkg::*;
#(
    parameter int WAIT_M0 = 26,
    parameter int WAIT_M1 = 46,
    parameter int WAIT_M2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_int_en,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       arb_none,
    input  logic       sw_release,
    input  logic       shift_wr,
    input  logic [1:0] clk_mode,
    output logic       gen_start,
    output logic       hold_wait,
    output logic       master_flag,
    output logic       addr_launch,
    output logic       rsv_pending,
    output logic       status_valid
);

    logic     bus_free;
    rsv_evt_t evt;

    i2c_bus_tracker u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (evt.fire),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .arb_none   (arb_none),
        .sw_release (sw_release),
        .bus_free   (bus_free)
    );

    i2c_rsv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_int_en (stop_int_en),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .shift_wr    (shift_wr),
        .bus_free    (bus_free),
        .evt         (evt),
        .gen_start   (gen_start),
        .hold_wait   (hold_wait),
        .master_flag (master_flag),
        .addr_launch (addr_launch),
        .rsv_pending (rsv_pending)
    );

    i2c_wait_timer #(
        .LEN_M0 (WAIT_M0),
        .LEN_M1 (WAIT_M1),
        .LEN_M2 (WAIT_M2)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (evt.load),
        .mode    (clk_mode),
        .expired (status_valid)
    );

endmodule

// File: rtl/i2c_start_rsv_chk.sv
// Module i2c_start_rsv_chk
// Port-level property checker, bound to every i2c_start_rsv instance.
// Assumes: synchronous active-low reset; checks are off while reset is low.
module i2c_start_rsv_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic stop_int_en,
    input logic start_det,
    input logic stop_det,
    input logic shift_wr,
    input logic gen_start,
    input logic hold_wait,
    input logic master_flag,
    input logic addr_launch,
    input logic rsv_pending,
    input logic status_valid
);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |=> !gen_start);

    // R3
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_pending |-> !gen_start && !master_flag);

    // R5
    auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_pending && stop_det && stop_int_en && !start_det)
        |=> gen_start && hold_wait && master_flag && !rsv_pending);

    // R6
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_wait && shift_wr && !stop_det) |=> addr_launch && !hold_wait && master_flag);

    // R6
    hold_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wait |-> master_flag);

    // R9
    arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_pending && start_det) |=> !rsv_pending && !master_flag);

    // R8
    timer_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_valid) |-> $past(start_req));

    // R7
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_pending && !stop_int_en) |=> !rsv_pending && !gen_start);

endmodule

bind i2c_start_rsv i2c_start_rsv_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .stop_int_en  (stop_int_en),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .shift_wr     (shift_wr),
    .gen_start    (gen_start),
    .hold_wait    (hold_wait),
    .master_flag  (master_flag),
    .addr_launch  (addr_launch),
    .rsv_pending  (rsv_pending),
    .status_valid (status_valid)
);

// File: tb/i2c_start_rsv_test.sv
module i2c_start_rsv_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 29;

    // {req,en,sdet,pdet,arb,swr,wr} | {gen,hold,mst,launch,pend}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0000000_00000, // 0  R1 idle
        12'b1000000_11100, // 1  R2 immediate start
        12'b0000000_01100, // 2  R2 pulse ends
        12'b0000001_00110, // 3  R6 launch
        12'b0000000_00100, // 4  R6 still master
        12'b0010000_00100, // 5  R4 own start seen
        12'b1100000_00100, // 6  R10 ignored while master
        12'b0001000_00000, // 7  R6 stop clears master
        12'b0010000_00000, // 8  R4 foreign start -> busy
        12'b1100000_00001, // 9  R3 reservation
        12'b0101000_11100, // 10 R5 auto start
        12'b0100001_00110, // 11 R6 launch
        12'b0001000_00000, // 12 R6 stop
        12'b0010000_00000, // 13 R4 busy
        12'b1100000_00001, // 14 R3 reserve
        12'b1100000_00001, // 15 R10 second request ignored
        12'b0110000_00000, // 16 R9 arbitration lost
        12'b1000000_00000, // 17 R7 busy, not armed
        12'b0000100_00000, // 18 R4 arb_none frees bus
        12'b1000000_11100, // 19 R4 start allowed
        12'b0001000_00000, // 20 R4 stop
        12'b0010000_00000, // 21 R4 busy
        12'b0000010_00000, // 22 R4 sw_release frees bus
        12'b1000000_11100, // 23 R4 start allowed
        12'b0001000_00000, // 24 R4 stop
        12'b0010000_00000, // 25 R4 busy
        12'b1100000_00001, // 26 R3 reserve
        12'b0000000_00000, // 27 R7 enable dropped cancels
        12'b0001000_00000  // 28 R7 stop fires nothing
    };
    localparam string TAG [NVEC] = '{
        "R1","R2","R2","R6","R6","R4","R10","R6","R4","R3",
        "R5","R6","R6","R4","R3","R10","R9","R7","R4","R4",
        "R4","R4","R4","R4","R4","R4","R3","R7","R7"
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_req, stop_int_en, start_det, stop_det;
    logic       arb_none, sw_release, shift_wr;
    logic [1:0] clk_mode;
    logic       gen_start, hold_wait, master_flag, addr_launch;
    logic       rsv_pending, status_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_start_rsv uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .stop_int_en  (stop_int_en),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .arb_none     (arb_none),
        .sw_release   (sw_release),
        .shift_wr     (shift_wr),
        .clk_mode     (clk_mode),
        .gen_start    (gen_start),
        .hold_wait    (hold_wait),
        .master_flag  (master_flag),
        .addr_launch  (addr_launch),
        .rsv_pending  (rsv_pending),
        .status_valid (status_valid)
    );

    function automatic logic [4:0] outs();
        return {gen_start, hold_wait, master_flag, addr_launch, rsv_pending};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, then sample at the next falling edge.
    task automatic cyc(input logic [6:0] in);
        {start_req, stop_int_en, start_det, stop_det, arb_none, sw_release, shift_wr} = in;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(7'b0);
        cyc(7'b0);
        rst_n = 1'b1;
    endtask

    // Count cycles status_valid stays low after a reservation request.
    task automatic wait_len(input logic [1:0] m, input bit second, output int len);
        len = 0;
        clk_mode = m;
        cyc(7'b0010000);              // bus busy
        cyc(7'b1100000);              // reserve, loads counter
        clk_mode = 2'b00;
        for (int i = 0; i < 200; i++) begin
            if (status_valid) break;
            len++;
            if (second && i == 9) cyc(7'b1100000);
            else cyc(7'b0100000);
        end
        cyc(7'b0110000);              // cancel via foreign start
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int len;
        rst_n = 1'b0;
        clk_mode = 2'b00;
        {start_req, stop_int_en, start_det, stop_det, arb_none, sw_release, shift_wr} = '0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 outputs", 32'(outs()), 32'h0);
        check("R1 status_valid", 32'(status_valid), 32'h1);

        for (int v = 0; v < NVEC; v++) begin
            cyc(VEC[v][11:5]);
            check($sformatf("%s row %0d", TAG[v], v), 32'(outs()), 32'(VEC[v][4:0]));
        end

        // R8 wait length per mode
        do_reset();
        wait_len(2'b00, 1'b0, len);
        check("R8 mode 00", 32'(len), 32'd26);
        wait_len(2'b01, 1'b0, len);
        check("R8 mode 01", 32'(len), 32'd46);
        wait_len(2'b10, 1'b0, len);
        check("R8 mode 10", 32'(len), 32'd16);
        wait_len(2'b11, 1'b0, len);
        check("R8 mode 11", 32'(len), 32'd16);

        // R10 second request mid-wait does not reload
        wait_len(2'b01, 1'b1, len);
        check("R10 no reload", 32'(len), 32'd46);

        // R7 ignored busy request leaves status_valid high
        cyc(7'b0010000);
        cyc(7'b1000000);
        check("R7 status_valid", 32'(status_valid), 32'h1);
        check("R7 pending", 32'(rsv_pending), 32'h0);

        // R2 immediate start loads counter: 16 cycles in mode 10
        cyc(7'b0001000);
        clk_mode = 2'b10;
        cyc(7'b1000000);
        check("R2 start", 32'(outs()), 32'b11100);
        check("R8 valid low", 32'(status_valid), 32'h0);
        clk_mode = 2'b00;

        // R1 reset mid-reservation returns to idle with bus free
        cyc(7'b0001000);
        cyc(7'b0010000);
        cyc(7'b1100000);
        check("R3 pending", 32'(rsv_pending), 32'h1);
        do_reset();
        check("R1 after reset", 32'(outs()), 32'h0);
        check("R1 status after reset", 32'(status_valid), 32'h1);
        cyc(7'b1000000);
        check("R1 bus free", 32'(outs()), 32'b11100);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule